// File: doc/BRIEF.md
# Digital Sync-Line Crosspoint Switch

This block routes eight single-bit digital lines (typically horizontal and vertical sync) to eight outputs. Any output may take any input, several outputs may share one input, and any output may be switched off. A switched-off output drives 0. The path from a routed input to its output has no register in it, so edges arrive at every output with the same combinational delay.

Routing is double-buffered. A 32-bit staging register is written either as one serial chain or one output field at a time, and it has no effect on the outputs by itself. A separate commit input copies the staged map into the live map that steers the outputs. A reset input turns every output off but leaves the staged map alone, so a later commit restores the previous routing. A serial chain output makes it possible to daisy-chain several devices on one shift clock.

All control pins are plain levels. They are sampled into the `clk` domain through a two-flop synchronizer, and edges of `shift_clk` are found in that domain. Each level of `shift_clk` and the data around each falling edge must therefore be held for at least four `clk` periods. A programming step takes effect at most four `clk` cycles after the falling edge of `shift_clk`.

Top module: `xbar_digital`

## Requirements
- R1: While `cs_n` is low and `par_mode` is 0, each falling edge of `shift_clk` shifts the 32-bit staging register up by one place, and `ser_in` enters at bit 0.
- R2: Output k owns staging bits [4k+3:4k]: bit 4k+3 is its enable and bits [4k+2:4k] are the index of its source input. So the first serial bit is output 7's enable, followed by output 7's select from MSB to LSB, and the last bit is output 0's select bit 0.
- R3: After each serial shift, `ser_out` holds the bit that just left staging bit 31. It changes only on serial shifts, so a second device fed from `ser_out` receives the first device's earlier contents in order.
- R4: While `cs_n` is low and `par_mode` is 1, a falling edge of `shift_clk` writes `wr_data` into the field of output `wr_addr`. Here `wr_data[3]` is the enable and `wr_data[2:0]` is the source. The other seven fields keep their values.
- R5: While `cs_n` is high, edges of `shift_clk` change neither the staging register nor `ser_out`, in either mode.
- R6: While `commit_n` is low, the live map is loaded from the staging register on every `clk` cycle, so the outputs follow the staged routing.
- R7: While `commit_n` is high, writes to the staging register do not change `sig_out`.
- R8: While `rst_n` is low, every output is 0. After release, every output stays off until the next commit. The staging register keeps its contents through reset, and that commit restores the staged routing.
- R9: An enabled output k equals `sig_in[select]` with no clock between them. A disabled output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the control pins |
| rst_n | input | 1 | Active-low reset; turns off all outputs, keeps the staged map |
| par_mode | input | 1 | 1 = one-field-at-a-time load, 0 = serial chain load |
| shift_clk | input | 1 | Programming strobe; acts on its falling edge |
| ser_in | input | 1 | Serial chain data in |
| ser_out | output | 1 | Serial chain data out for cascading |
| wr_addr | input | 3 | Output index for a one-field write |
| wr_data | input | 4 | Field value: [3] enable, [2:0] source input |
| cs_n | input | 1 | Active-low device select for programming |
| commit_n | input | 1 | Active-low copy of staging into the live map |
| sig_in | input | 8 | Digital input lines |
| sig_out | output | 8 | Routed digital output lines |

## Verification
Two distinct serial maps are used. One is a reversal with all outputs enabled. The other has every odd output disabled and a rotated source. Each map is checked against several `sig_in` patterns (alternating bits, a single hot bit, all ones), so that a wrong select, a swapped field order or a stuck enable gives a wrong output bit. The serial output is compared bit by bit while the second map pushes out the first, which checks both chain order and cascade timing. A single-field write, programming attempts with the device deselected, writes without a commit, and a reset followed by a commit show apart the staging, live-map and retention behaviour.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_N_IN        = 8;
  localparam int XB_N_OUT       = 8;
  localparam int XB_SYNC_STAGES = 2;
endpackage

// File: rtl/xbar_sync.sv
module xbar_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= RST_V;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[i] <= RST_V;
          else        st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/xbar_prog.sv
module xbar_prog #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclk_s,
  input  logic                     sdi_s,
  input  logic                     par_s,
  input  logic                     cs_n_s,
  input  logic [$clog2(N_OUT)-1:0] addr_s,
  input  logic [SEL_W:0]           data_s,
  output logic [N_OUT*(SEL_W+1)-1:0] prog_q,
  output logic                     sdo
);
  localparam int FW = SEL_W + 1;
  localparam int CW = N_OUT * FW;

  logic sclk_d;
  logic fall, shift_ev, wr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign fall     = sclk_d & ~sclk_s;
  assign shift_ev = fall & ~cs_n_s & ~par_s;
  assign wr_ev    = fall & ~cs_n_s & par_s;

  // staging map: deliberately without reset so it survives rst_n
  always_ff @(posedge clk) begin
    if (shift_ev)   prog_q <= {prog_q[CW-2:0], sdi_s};
    else if (wr_ev) prog_q[addr_s*FW +: FW] <= data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo <= 1'b0;
    else if (shift_ev) sdo <= prog_q[CW-1];
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (prog_q[0] == $past(sdi_s)) && (prog_q[CW-1:1] == $past(prog_q[CW-2:0]))); // R1
  AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> sdo == $past(prog_q[CW-1])); // R3
  AST_FIELD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> prog_q[$past(addr_s)*FW +: FW] == $past(data_s)); // R4
  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(prog_q) && $stable(sdo)); // R5
endmodule

// File: rtl/xbar_live.sv
module xbar_live #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     commit_n_s,
  input  logic [N_OUT*($clog2(N_IN)+1)-1:0]        prog_q,
  input  logic [N_IN-1:0]                          sig_in,
  output logic [N_OUT-1:0]                         sig_out
);
  localparam int SEL_W = $clog2(N_IN);
  localparam int FW    = SEL_W + 1;
  localparam int CW    = N_OUT * FW;

  logic [CW-1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           live_q <= '0;
    else if (!commit_n_s) live_q <= prog_q;
  end

  genvar k;
  generate
    for (k = 0; k < N_OUT; k++) begin : g_out
      logic             en;
      logic [SEL_W-1:0] sel;
      assign en         = live_q[k*FW + SEL_W];
      assign sel        = live_q[k*FW +: SEL_W];
      assign sig_out[k] = en & sig_in[sel];
    end
  endgenerate

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_n_s |=> live_q == $past(prog_q)); // R6
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_n_s |=> $stable(live_q)); // R7
  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |-> sig_out == '0); // R8
endmodule

// File: rtl/xbar_digital.sv
module xbar_digital
  import xbar_pkg::*;
#(
  parameter int N_IN   = XB_N_IN,
  parameter int N_OUT  = XB_N_OUT,
  parameter int STAGES = XB_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     par_mode,
  input  logic                     shift_clk,
  input  logic                     ser_in,
  output logic                     ser_out,
  input  logic [$clog2(N_OUT)-1:0] wr_addr,
  input  logic [$clog2(N_IN):0]    wr_data,
  input  logic                     cs_n,
  input  logic                     commit_n,
  input  logic [N_IN-1:0]          sig_in,
  output logic [N_OUT-1:0]         sig_out
);
  localparam int SEL_W  = $clog2(N_IN);
  localparam int ADDR_W = $clog2(N_OUT);
  localparam int FW     = SEL_W + 1;
  localparam int CW     = N_OUT * FW;
  localparam int BW     = 5 + ADDR_W + FW;

  logic [BW-1:0]     raw, synced;
  logic              par_s, sclk_s, sdi_s, cs_n_s, commit_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [FW-1:0]     data_s;
  logic [CW-1:0]     prog_q;

  assign raw = {par_mode, shift_clk, ser_in, wr_addr, wr_data, cs_n, commit_n};

  xbar_sync #(.W(BW), .STAGES(STAGES), .RST_V({BW{1'b1}})) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (synced)
  );

  assign {par_s, sclk_s, sdi_s, addr_s, data_s, cs_n_s, commit_n_s} = synced;

  xbar_prog #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk_s(sclk_s),
    .sdi_s (sdi_s),
    .par_s (par_s),
    .cs_n_s(cs_n_s),
    .addr_s(addr_s),
    .data_s(data_s),
    .prog_q(prog_q),
    .sdo   (ser_out)
  );

  xbar_live #(.N_IN(N_IN), .N_OUT(N_OUT)) u_live (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_n_s(commit_n_s),
    .prog_q    (prog_q),
    .sig_in    (sig_in),
    .sig_out   (sig_out)
  );
endmodule

// File: tb/sim_xbar_digital.sv
module sim_xbar_digital;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       par_mode = 1'b0;
  logic       shift_clk = 1'b1;
  logic       ser_in = 1'b0;
  logic       ser_out;
  logic [2:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       cs_n = 1'b1;
  logic       commit_n = 1'b1;
  logic [7:0] sig_in = '0;
  logic [7:0] sig_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] staged;   // bench model of the staging register
  logic [31:0] live;     // bench model of the live map
  logic [31:0] w1, w2;

  always #2 clk = ~clk;  // 250 MHz

  xbar_digital u0 (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .shift_clk(shift_clk),
    .ser_in(ser_in), .ser_out(ser_out), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_n(cs_n), .commit_n(commit_n), .sig_in(sig_in), .sig_out(sig_out)
  );

  function automatic logic [7:0] route(input logic [31:0] w, input logic [7:0] din);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] s;
      s = w[4*k +: 3];
      r[k] = w[4*k+3] & din[s];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    idle(5); shift_clk = 1'b0; idle(5); shift_clk = 1'b1; idle(5);
  endtask

  task automatic commit();
    @(negedge clk); commit_n = 1'b0; idle(5); commit_n = 1'b1; idle(5);
    live = staged;
  endtask

  task automatic check_routes(input string req);
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'h10; pats[3] = 8'hFF;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); sig_in = pats[p]; #1;
      check(req, {24'h0, sig_out}, {24'h0, route(live, pats[p])});
    end
  endtask

  // serial load, MSB first; optionally compare ser_out with the previous map
  task automatic serial_load(input logic [31:0] w, input bit chk_chain, input string req);
    logic [31:0] old;
    old = staged;
    @(negedge clk); par_mode = 1'b0; cs_n = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      ser_in = w[i];
      strobe();
      if (chk_chain) check(req, {31'h0, ser_out}, {31'h0, old[i]});
    end
    cs_n = 1'b1;
    staged = w;
  endtask

  task automatic field_write(input logic [2:0] a, input logic [3:0] d, input bit sel);
    @(negedge clk); par_mode = 1'b1; cs_n = ~sel; wr_addr = a; wr_data = d;
    strobe();
    cs_n = 1'b1; par_mode = 1'b0;
    if (sel) staged[4*a +: 4] = d;
  endtask

  task automatic t_reset();
    live = '0;
    check("R8 reset state", {24'h0, sig_out}, 32'h0);
    sig_in = 8'hFF; #1;
    check("R8 reset outputs off", {24'h0, sig_out}, 32'h0);
  endtask

  task automatic t_serial_first();
    serial_load(w1, 1'b0, "");
    check_routes("R7 no effect before commit");
    commit();
    check_routes("R1 R2 R6 R9 serial map one");
  endtask

  task automatic t_serial_second();
    serial_load(w2, 1'b1, "R3 chain out");
    check_routes("R7 second load held");
    commit();
    check_routes("R2 R9 serial map two with disables");
  endtask

  task automatic t_field();
    field_write(3'd2, 4'b1011, 1'b1);
    field_write(3'd1, 4'b1110, 1'b1);
    check_routes("R7 field write held");
    commit();
    check_routes("R4 field write");
    field_write(3'd6, 4'b0101, 1'b1);
    commit();
    @(negedge clk); sig_in = 8'hFF; #1;
    check("R9 disabled output is 0", {31'h0, sig_out[6]}, 32'h0);
  endtask

  task automatic t_deselect();
    logic so;
    so = ser_out;
    @(negedge clk); par_mode = 1'b0; cs_n = 1'b1;
    for (int i = 0; i < 6; i++) begin ser_in = i[0]; strobe(); end
    check("R5 ser_out untouched", {31'h0, ser_out}, {31'h0, so});
    field_write(3'd0, 4'b0000, 1'b0);
    commit();
    check_routes("R5 deselected writes ignored");
  endtask

  task automatic t_reset_retain();
    @(negedge clk); rst_n = 1'b0; sig_in = 8'hFF; #1;
    check("R8 outputs off in reset", {24'h0, sig_out}, 32'h0);
    idle(4); rst_n = 1'b1; idle(6);
    live = '0;
    check("R8 outputs off after release", {24'h0, sig_out}, 32'h0);
    commit();
    check_routes("R8 staged map kept through reset");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      w1[4*k +: 4] = {1'b1, 3'(7 - k)};
      w2[4*k +: 4] = {~k[0], 3'((k + 3) % 8)};
    end
    staged = '0;
    #1 rst_n = 1'b0;
    idle(5);
    t_reset();
    rst_n = 1'b1;
    idle(5);
    t_serial_first();
    t_serial_second();
    t_field();
    t_deselect();
    t_reset_retain();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule